// File: doc/BRIEF.md
# Sign-Extending Load/Store Unit

This unit executes the memory-transfer instructions of a small register machine: register loads with zero or sign extension, and stores of a 32-bit immediate. Each instruction arrives as one opcode byte together with a base address, a signed 16-bit displacement, a 32-bit immediate and a destination register index. The unit splits the opcode into its mode, size and class fields. It rejects any combination it does not implement. It computes the effective address and issues a single request on a little-endian, 64-bit-wide memory port with byte enables.

Only one transfer is in flight at a time. While a transfer waits for its response, the unit holds `busy` high and ignores new issues. When the response arrives, a load returns its value on the writeback port one cycle later, extended to 64 bits. A store ends without a writeback. Illegal opcodes and misaligned addresses produce a one-cycle fault report and never reach memory.

Top module: `ldst_sx_unit`

## Requirements
- R1: The opcode byte is split as mode in bits 7:5, size in bits 4:3 and class in bits 2:0. The legal combinations are: class 1 with mode 3 (any size), class 1 with mode 4 and a size other than 3, and class 2 with mode 3. Any other opcode raises `fault_valid` with `fault_code` 1 one cycle after the issue, and no memory request is made.
- R2: The effective address is the base plus the sign-extended 16-bit displacement, modulo 2^ADDR_W. It appears on `mem_req_addr` together with `mem_req_valid` one cycle after an accepted issue.
- R3: With mode 3 and class 1, the load size is coded as 0 = 32 bits, 1 = 16 bits, 2 = 8 bits, 3 = 64 bits. The loaded value is zero-extended to 64 bits.
- R4: With mode 4 and class 1, the unit performs an 8-, 16- or 32-bit load and copies the top bit of the loaded value into all higher bits of the 64-bit result.
- R5: With mode 3 and class 2, the unit writes the low bytes of the immediate, as many as the size selects. `mem_req_we` is 1, and exactly those byte enables are set.
- R6: A 64-bit immediate store writes the immediate sign-extended to 64 bits.
- R7: An access whose effective address is not a multiple of its size raises `fault_valid` with `fault_code` 2 one cycle after the issue, and no request is made. An illegal opcode takes precedence over misalignment.
- R8: `busy` rises one cycle after an accepted issue and falls one cycle after the edge at which `mem_rsp_valid` is seen. At most one request is outstanding at a time. Issues presented while `busy` is high are ignored.
- R9: One cycle after a load's response, `wb_valid` pulses with the saved destination index and the extended data. A store never pulses `wb_valid`.
- R10: While reset is asserted and after it is released, `busy`, `mem_req_valid`, `wb_valid` and `fault_valid` are all 0 until an issue arrives.
- R11: The port is little-endian. Address bits 2:0 choose the starting byte lane: byte enables and store data are shifted up by that many lanes, and load data are taken from that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction present this cycle |
| issue_op | input | 8 | Opcode byte (mode, size, class) |
| issue_rd | input | RIDX_W | Destination register index |
| issue_base | input | ADDR_W | Base address register value |
| issue_off | input | OFF_W | Signed displacement |
| issue_imm | input | IMM_W | Store immediate |
| busy | output | 1 | A transfer is in flight |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Byte address of the access |
| mem_req_be | output | DATA_W/8 | Byte enables |
| mem_req_wdata | output | DATA_W | Lane-aligned write data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_rdata | input | DATA_W | Word containing the addressed bytes |
| wb_valid | output | 1 | Load result valid |
| wb_rd | output | RIDX_W | Destination register index |
| wb_data | output | DATA_W | Extended load result |
| fault_valid | output | 1 | Instruction rejected |
| fault_code | output | 2 | 1 = illegal opcode, 2 = misaligned |

## Verification
The assertions check the protocol rules on every cycle. A request is only issued while busy and never in two consecutive cycles. A request address is always aligned to its size. A writeback only follows a response that was seen while busy. A fault never coincides with a request or with busy. Only the bench scenarios can show the data-dependent behaviour: the decoded legality of each opcode, zero versus sign extension of each load size, how a stored immediate lands in memory and is read back, and that an issue presented while busy leaves memory untouched.

// File: rtl/ldst_sx_pkg.sv
package ldst_sx_pkg;

  typedef enum logic [1:0] {
    SZ_WORD  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_BYTE  = 2'd2,
    SZ_DWORD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ILLEGAL = 2'd1,
    FLT_ALIGN   = 2'd2
  } fault_e;

  localparam logic [2:0] MODE_PLAIN = 3'h3;
  localparam logic [2:0] MODE_SEXT  = 3'h4;
  localparam logic [2:0] CLS_LOAD   = 3'h1;
  localparam logic [2:0] CLS_STIMM  = 3'h2;

endpackage

// File: rtl/ldst_sx_decode.sv
module ldst_sx_decode
  import ldst_sx_pkg::*;
(
  input  logic [7:0]  op,
  output logic        is_load,
  output logic        is_store,
  output logic        sext,
  output xfer_size_e  size,
  output logic        illegal
);

  logic [2:0] mode;
  logic [2:0] cls;

  always_comb begin
    mode     = op[7:5];
    cls      = op[2:0];
    size     = xfer_size_e'(op[4:3]);
    is_load  = 1'b0;
    is_store = 1'b0;
    sext     = 1'b0;
    if (cls == CLS_LOAD && mode == MODE_PLAIN) begin
      is_load = 1'b1;
    end else if (cls == CLS_LOAD && mode == MODE_SEXT && size != SZ_DWORD) begin
      is_load = 1'b1;
      sext    = 1'b1;
    end else if (cls == CLS_STIMM && mode == MODE_PLAIN) begin
      is_store = 1'b1;
    end
    illegal = !(is_load || is_store);
  end

endmodule

// File: rtl/ldst_sx_store_pack.sv
module ldst_sx_store_pack
  import ldst_sx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  xfer_size_e          size,
  input  logic [LANE_W-1:0]   lane,
  input  logic [IMM_W-1:0]    imm,
  output logic [NB-1:0]       be,
  output logic [DATA_W-1:0]   wdata
);

  logic [DATA_W-1:0] value;
  logic [NB-1:0]     mask;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        value = DATA_W'(imm[7:0]);
        mask  = NB'(1);
      end
      SZ_HALF: begin
        value = DATA_W'(imm[15:0]);
        mask  = NB'(3);
      end
      SZ_WORD: begin
        value = DATA_W'(imm);
        mask  = NB'(15);
      end
      default: begin
        value = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        mask  = {NB{1'b1}};
      end
    endcase
    be    = mask << lane;
    wdata = value << {lane, 3'b000};
  end

endmodule

// File: rtl/ldst_sx_load_extract.sv
module ldst_sx_load_extract
  import ldst_sx_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_W-1:0] lane,
  input  xfer_size_e        size,
  input  logic              sext,
  output logic [DATA_W-1:0] data
);

  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = rdata >> {lane, 3'b000};
    case (size)
      SZ_BYTE:
        data = sext ? {{(DATA_W-8){shifted[7]}}, shifted[7:0]}
                    : DATA_W'(shifted[7:0]);
      SZ_HALF:
        data = sext ? {{(DATA_W-16){shifted[15]}}, shifted[15:0]}
                    : DATA_W'(shifted[15:0]);
      SZ_WORD:
        data = sext ? {{(DATA_W-32){shifted[31]}}, shifted[31:0]}
                    : DATA_W'(shifted[31:0]);
      default:
        data = shifted;
    endcase
  end

endmodule

// File: rtl/ldst_sx_unit.sv
module ldst_sx_unit
  import ldst_sx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32,
  parameter int RIDX_W = 4,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [7:0]        issue_op,
  input  logic [RIDX_W-1:0] issue_rd,
  input  logic [ADDR_W-1:0] issue_base,
  input  logic [OFF_W-1:0]  issue_off,
  input  logic [IMM_W-1:0]  issue_imm,
  output logic              busy,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [NB-1:0]     mem_req_be,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_rd,
  output logic [DATA_W-1:0] wb_data,
  output logic              fault_valid,
  output logic [1:0]        fault_code
);

  logic       d_load, d_store, d_sext, d_illegal;
  xfer_size_e d_size;

  ldst_sx_decode i_decode (
    .op       (issue_op),
    .is_load  (d_load),
    .is_store (d_store),
    .sext     (d_sext),
    .size     (d_size),
    .illegal  (d_illegal)
  );

  logic [ADDR_W-1:0] eff_addr;
  logic [LANE_W-1:0] align_mask;
  logic              misalign;

  always_comb begin
    eff_addr = issue_base + {{(ADDR_W-OFF_W){issue_off[OFF_W-1]}}, issue_off};
    case (d_size)
      SZ_BYTE: align_mask = LANE_W'(0);
      SZ_HALF: align_mask = LANE_W'(1);
      SZ_WORD: align_mask = LANE_W'(3);
      default: align_mask = {LANE_W{1'b1}};
    endcase
    misalign = |(eff_addr[LANE_W-1:0] & align_mask);
  end

  logic [NB-1:0]     pk_be;
  logic [DATA_W-1:0] pk_wdata;

  ldst_sx_store_pack #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_pack (
    .size  (d_size),
    .lane  (eff_addr[LANE_W-1:0]),
    .imm   (issue_imm),
    .be    (pk_be),
    .wdata (pk_wdata)
  );

  // Context of the transfer in flight
  logic              h_load;
  logic              h_sext;
  xfer_size_e        h_size;
  logic [LANE_W-1:0] h_lane;
  logic [RIDX_W-1:0] h_rd;
  logic [DATA_W-1:0] ext_data;

  ldst_sx_load_extract #(.DATA_W(DATA_W)) i_extract (
    .rdata (mem_rsp_rdata),
    .lane  (h_lane),
    .size  (h_size),
    .sext  (h_sext),
    .data  (ext_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_be    <= '0;
      mem_req_wdata <= '0;
      wb_valid      <= 1'b0;
      wb_rd         <= '0;
      wb_data       <= '0;
      fault_valid   <= 1'b0;
      fault_code    <= FLT_NONE;
      h_load        <= 1'b0;
      h_sext        <= 1'b0;
      h_size        <= SZ_WORD;
      h_lane        <= '0;
      h_rd          <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      wb_valid      <= 1'b0;
      fault_valid   <= 1'b0;
      if (!busy) begin
        if (issue_valid) begin
          if (d_illegal) begin
            fault_valid <= 1'b1;
            fault_code  <= FLT_ILLEGAL;
          end else if (misalign) begin
            fault_valid <= 1'b1;
            fault_code  <= FLT_ALIGN;
          end else begin
            busy          <= 1'b1;
            mem_req_valid <= 1'b1;
            mem_req_we    <= d_store;
            mem_req_addr  <= eff_addr;
            mem_req_be    <= pk_be;
            mem_req_wdata <= d_store ? pk_wdata : '0;
            h_load        <= d_load;
            h_sext        <= d_sext;
            h_size        <= d_size;
            h_lane        <= eff_addr[LANE_W-1:0];
            h_rd          <= issue_rd;
          end
        end
      end else if (mem_rsp_valid) begin
        busy <= 1'b0;
        if (h_load) begin
          wb_valid <= 1'b1;
          wb_rd    <= h_rd;
          wb_data  <= ext_data;
        end
      end
    end
  end

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy); // R8

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid); // R8

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rsp_valid) |=> !busy); // R8

  AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(busy && mem_rsp_valid)); // R9

  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (!mem_req_valid && !busy)); // R7

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && $countones(mem_req_be) > 1)
      |-> ((mem_req_addr[LANE_W-1:0] & LANE_W'($countones(mem_req_be) - 1)) == '0)); // R7

  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_be != '0)); // R5

endmodule

// File: tb/test_ldst_sx_unit.sv
module test_ldst_sx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [7:0]  issue_op = '0;
  logic [3:0]  issue_rd = '0;
  logic [31:0] issue_base = '0;
  logic [15:0] issue_off = '0;
  logic [31:0] issue_imm = '0;
  logic        busy, mem_req_valid, mem_req_we;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_be;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_rdata;
  logic        wb_valid;
  logic [3:0]  wb_rd;
  logic [63:0] wb_data;
  logic        fault_valid;
  logic [1:0]  fault_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_sx_unit i_ldst_sx_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_rd(issue_rd), .issue_base(issue_base), .issue_off(issue_off),
    .issue_imm(issue_imm), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .wb_data(wb_data), .fault_valid(fault_valid), .fault_code(fault_code)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        is_fault;
    logic [1:0]  code;
    logic [3:0]  rd;
    logic [63:0] data;
    string       tag;
  } out_t;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [7:0]  be;
    logic [63:0] wdata;
    string       tag;
  } req_t;

  out_t exp_out[$];
  req_t exp_req[$];

  // Memory model and byte-level shadow
  logic [63:0] mem [0:63];
  logic [7:0]  shadow [0:511];
  logic [63:0] hold;
  int          cnt;
  logic        pend;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    for (int w = 0; w < 64; w++)
      for (int k = 0; k < 8; k++) mem[w][8*k +: 8] = pat(w*8 + k);
    for (int i = 0; i < 512; i++) shadow[i] = pat(i);
  end

  always @(posedge clk) begin
    if (rst) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      pend <= 1'b0;
      cnt <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid) begin
        if (mem_req_we)
          for (int k = 0; k < 8; k++)
            if (mem_req_be[k]) mem[mem_req_addr[8:3]][8*k +: 8] <= mem_req_wdata[8*k +: 8];
        hold <= mem[mem_req_addr[8:3]];
        pend <= 1'b1;
        cnt  <= LAT;
      end else if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= hold;
          pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
    end
  end

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req_valid) begin
        checks++;
        if (exp_req.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected request addr=%h expected none", mem_req_addr);
        end else begin
          req_t r;
          logic [63:0] m;
          r = exp_req.pop_front();
          for (int k = 0; k < 8; k++) m[8*k +: 8] = {8{r.be[k]}};
          if (mem_req_addr !== r.addr || mem_req_we !== r.we || mem_req_be !== r.be ||
              (r.we && ((mem_req_wdata & m) !== r.wdata))) begin
            errors++;
            $display("FAIL %s req addr=%h we=%b be=%h wd=%h expected addr=%h we=%b be=%h wd=%h",
                     r.tag, mem_req_addr, mem_req_we, mem_req_be, mem_req_wdata & m,
                     r.addr, r.we, r.be, r.wdata);
          end
        end
      end
      if (wb_valid || fault_valid) begin
        checks++;
        if (exp_out.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected output wb=%b fault=%b expected none", wb_valid, fault_valid);
        end else begin
          out_t e;
          e = exp_out.pop_front();
          if (e.is_fault) begin
            if (!fault_valid || wb_valid || fault_code !== e.code) begin
              errors++;
              $display("FAIL %s fault=%b code=%0d wb=%b expected fault code=%0d",
                       e.tag, fault_valid, fault_code, wb_valid, e.code);
            end
          end else if (!wb_valid || fault_valid || wb_rd !== e.rd || wb_data !== e.data) begin
            errors++;
            $display("FAIL %s wb=%b rd=%0d data=%h expected rd=%0d data=%h",
                     e.tag, wb_valid, wb_rd, wb_data, e.rd, e.data);
          end
        end
      end
    end
  end

  // Driver: computes expectations from the requirements
  task automatic issue(input logic [7:0] op, input logic [3:0] rd, input logic [31:0] base,
                       input logic [15:0] off, input logic [31:0] imm, input string tag);
    logic [2:0]  mode, cls;
    logic [1:0]  sz;
    logic [31:0] a;
    int          nb;
    logic        legal;
    out_t        o;
    req_t        r;
    while (busy) @(negedge clk);
    mode = op[7:5]; sz = op[4:3]; cls = op[2:0];
    a = base + {{16{off[15]}}, off};
    nb = (sz == 0) ? 4 : (sz == 1) ? 2 : (sz == 2) ? 1 : 8;
    legal = (cls == 1 && mode == 3) || (cls == 1 && mode == 4 && sz != 3) ||
            (cls == 2 && mode == 3);
    o.tag = tag; o.rd = rd; o.data = '0; o.code = 0; o.is_fault = 0;
    if (!legal) begin
      o.is_fault = 1; o.code = 1; exp_out.push_back(o);
    end else if ((a % nb) != 0) begin
      o.is_fault = 1; o.code = 2; exp_out.push_back(o);
    end else begin
      r.tag = tag; r.addr = a; r.we = (cls == 2); r.be = '0; r.wdata = '0;
      for (int k = 0; k < nb; k++) begin
        logic [7:0] b;
        b = (k < 4) ? imm[8*k +: 8] : {8{imm[31]}};
        r.be[a[2:0] + k] = 1'b1;
        if (cls == 2) begin
          r.wdata[8*(a[2:0] + k) +: 8] = b;
          shadow[a[8:0] + k] = b;
        end else begin
          o.data[8*k +: 8] = shadow[a[8:0] + k];
        end
      end
      if (cls == 1) begin
        if (mode == 4 && o.data[8*nb-1])
          for (int k = nb; k < 8; k++) o.data[8*k +: 8] = 8'hff;
        exp_out.push_back(o);
      end
      exp_req.push_back(r);
    end
    issue_op = op; issue_rd = rd; issue_base = base; issue_off = off; issue_imm = imm;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy || mem_req_valid || wb_valid || fault_valid) begin
      errors++;
      $display("FAIL R10 in reset busy=%b req=%b wb=%b flt=%b expected 0",
               busy, mem_req_valid, wb_valid, fault_valid);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (busy || mem_req_valid || wb_valid || fault_valid) begin
      errors++;
      $display("FAIL R10 after reset busy=%b req=%b wb=%b flt=%b expected 0",
               busy, mem_req_valid, wb_valid, fault_valid);
    end

    // R3 zero-extending loads of every size; R2 negative displacement; R11 lanes
    issue(8'h79, 4'd1, 32'h100, 16'h0000, 32'h0, "R3 ld64");
    issue(8'h61, 4'd2, 32'h108, 16'hfffc, 32'h0, "R2 ld32 neg off");
    issue(8'h69, 4'd3, 32'h100, 16'h0006, 32'h0, "R11 ld16 lane6");
    issue(8'h71, 4'd4, 32'h100, 16'h0003, 32'h0, "R3 ld8 lane3");
    issue(8'h71, 4'd5, 32'h0ff, 16'h0001, 32'h0, "R11 ld8 lane0");
    // R5 stores of each size, R6 64-bit sign extension
    issue(8'h72, 4'd0, 32'h040, 16'h0005, 32'h12345680, "R5 st8");
    issue(8'h6a, 4'd0, 32'h048, 16'h0002, 32'hcafe8001, "R5 st16");
    issue(8'h62, 4'd0, 32'h050, 16'h0004, 32'hdeadbeef, "R5 st32");
    issue(8'h7a, 4'd0, 32'h058, 16'h0000, 32'h80000001, "R6 st64 neg");
    issue(8'h7a, 4'd0, 32'h060, 16'h0000, 32'h7ffffff0, "R6 st64 pos");
    // R4 sign-extending loads, negative and positive
    issue(8'h91, 4'd6, 32'h045, 16'h0000, 32'h0, "R4 ldsx8 neg");
    issue(8'h71, 4'd7, 32'h045, 16'h0000, 32'h0, "R3 ld8 zero of neg");
    issue(8'h89, 4'd8, 32'h04a, 16'h0000, 32'h0, "R4 ldsx16 neg");
    issue(8'h89, 4'd9, 32'h056, 16'h0000, 32'h0, "R4 ldsx16 dead");
    issue(8'h81, 4'd10, 32'h054, 16'h0000, 32'h0, "R4 ldsx32 neg");
    issue(8'h81, 4'd11, 32'h060, 16'h0000, 32'h0, "R4 ldsx32 pos");
    issue(8'h79, 4'd12, 32'h058, 16'h0000, 32'h0, "R6 ld64 readback");
    issue(8'h79, 4'd13, 32'h060, 16'h0000, 32'h0, "R6 ld64 readback pos");
    // R1 illegal opcodes
    issue(8'h99, 4'd1, 32'h100, 16'h0000, 32'h0, "R1 sx64 illegal");
    issue(8'hc1, 4'd1, 32'h100, 16'h0000, 32'h0, "R1 mode6 illegal");
    issue(8'h60, 4'd1, 32'h100, 16'h0000, 32'h0, "R1 class0 illegal");
    issue(8'h82, 4'd1, 32'h100, 16'h0000, 32'h0, "R1 sx store illegal");
    // R7 misaligned, and precedence
    issue(8'h61, 4'd1, 32'h100, 16'h0002, 32'h0, "R7 ld32 misaligned");
    issue(8'h6a, 4'd1, 32'h101, 16'h0000, 32'h1, "R7 st16 misaligned");
    issue(8'h79, 4'd1, 32'h104, 16'h0000, 32'h0, "R7 ld64 misaligned");
    issue(8'hc1, 4'd1, 32'h101, 16'h0000, 32'h0, "R7 illegal wins");
    // R8 issue while busy is ignored
    issue(8'h79, 4'd2, 32'h080, 16'h0000, 32'h0, "R8 ld64 before ignored");
    issue_op = 8'h62; issue_base = 32'h088; issue_off = '0; issue_imm = 32'h5a5a5a5a;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    checks++;
    if (!busy) begin
      errors++;
      $display("FAIL R8 busy=%b expected 1 during transfer", busy);
    end
    issue(8'h79, 4'd3, 32'h088, 16'h0000, 32'h0, "R8 ignored store left memory");
    // R9 store followed immediately by load, no writeback for store
    issue(8'h62, 4'd0, 32'h1f8, 16'h0004, 32'h00c0ffee, "R9 st32 top");
    issue(8'h79, 4'd14, 32'h1f8, 16'h0000, 32'h0, "R9 ld64 top");

    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (exp_out.size() != 0 || exp_req.size() != 0) begin
      errors++;
      $display("FAIL R9 pending outputs=%0d requests=%0d expected 0 0",
               exp_out.size(), exp_req.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule